// File: doc/BRIEF.md
# Channel-Gain Scan Sequencer

The block walks an analog input front end through a host-programmed scan list. Each list slot holds a 4-bit input channel code and a 2-bit gain code, so every sample can use its own gain, and channels may be listed in any order or repeated. On each pacer tick the block drives the current slot's channel and gain to the multiplexer and amplifier. It pulses a convert strobe to the converter and then steps to the next slot. After the programmed last slot it returns to slot 0.

The converter answers with a one-cycle done pulse carrying the sample. The sample leaves the block on a valid/ready stream together with the index of the slot it came from. Back-pressure rule: once `smp_valid` is high, the data and index hold still until `smp_ready` is seen high at a clock edge. The conversion counts as busy from the strobe until that handshake, so a stalled consumer turns later pacer ticks into overruns. The host loads the list and the last-slot index, and picks single-ended or differential input mode. It starts and stops the scan with single-cycle pulses. The pacer is expected to tick at no more than 200 kHz.

Top module: `scan_sequencer`

## Requirements
- R1: A list write while idle stores `lst_wr_chan` (4 bits) and `lst_wr_gain` (2 bits) at slot `lst_wr_idx`. There are 176 slots, indices 0 to 175. A converted sample from slot k uses exactly the channel and gain last stored at slot k.
- R2: List writes and last-slot writes are ignored while `scanning` is high.
- R3: A pacer tick accepted while scanning and not busy has two effects in the next cycle: `conv_strobe` is high for exactly one cycle, and `mux_chan`/`mux_gain` show the current slot's entry.
- R4: After each accepted tick the slot index advances by one, and it returns to 0 after the last-slot index. A last-slot value above 175 is stored as 175.
- R5: In differential mode (`mux_diff`=1) a slot whose channel code is 8 or above raises the sticky `chan_err`. That slot produces no strobe, but the index still advances. In single-ended mode all 16 codes are converted.
- R6: A pacer tick that arrives while scanning and busy sets the sticky `overrun`. That tick produces no strobe and does not move the index.
- R7: An `adc_done` pulse during a conversion raises `smp_valid` with `smp_data` equal to `adc_data` and `smp_idx` equal to the slot index. Valid, data and index hold until a cycle with `smp_ready` high.
- R8: A `start` pulse while idle sets `scanning`, resets the index to 0, clears both sticky flags and latches `diff_mode` into `mux_diff`. A `stop` pulse clears `scanning`, and no strobe follows. A conversion already started is still delivered.
- R9: After reset, `scanning`, `overrun`, `chan_err`, `smp_valid` and `conv_strobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin scanning from slot 0 (acts only when idle) |
| stop | input | 1 | End scanning |
| diff_mode | input | 1 | Differential (1) or single-ended (0), latched at start |
| lst_wr_en | input | 1 | Scan list write strobe |
| lst_wr_idx | input | 8 | Slot to write |
| lst_wr_chan | input | 4 | Channel code for the slot |
| lst_wr_gain | input | 2 | Gain code for the slot |
| last_wr_en | input | 1 | Last-slot index write strobe |
| last_wr_val | input | 8 | Last-slot index |
| pacer_tick | input | 1 | Sample pacing pulse |
| mux_chan | output | 4 | Channel to the input multiplexer |
| mux_gain | output | 2 | Gain code to the amplifier |
| mux_diff | output | 1 | Input mode in use |
| conv_strobe | output | 1 | Start-conversion pulse |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 16 | Converted sample |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready |
| smp_data | output | 16 | Sample value |
| smp_idx | output | 8 | Slot the sample came from |
| scanning | output | 1 | Scan active |
| overrun | output | 1 | Sticky: tick dropped while busy |
| chan_err | output | 1 | Sticky: illegal differential channel |

## Verification
The hardest situation to reach is a tick that lands while the previous conversion is still busy. The bench has to show that this tick leaves the index in place, so the next accepted tick converts the slot that would otherwise have been skipped. The bench gets there by issuing two ticks on back-to-back cycles. It then lets the scoreboard's own slot model predict the index of the next sample. Back-pressure is reached by holding `smp_ready` low across a finished conversion. Illegal differential codes come from the regular list contents once the scan is restarted in differential mode.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 2;
  localparam int DIFF_PAIRS = (1 << CHAN_W) / 2;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [GAIN_W-1:0] gain;
  } scan_entry_t;
endpackage

// File: rtl/scan_list_ram.sv
module scan_list_ram
  import scan_pkg::*;
#(
  parameter int DEPTH = 176,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  scan_entry_t       wr_entry,
  input  logic [IDX_W-1:0]  rd_idx,
  output scan_entry_t       rd_entry
);
  scan_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx < IDX_W'(DEPTH))) mem[wr_idx] <= wr_entry;
  end

  assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/scan_index_ctl.sv
module scan_index_ctl #(
  parameter int DEPTH = 176,
  localparam int IDX_W = $clog2(DEPTH),
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DEPTH - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic              last_wr_en,
  input  logic [IDX_W-1:0]  last_wr_val,
  output logic [IDX_W-1:0]  cur_idx
);
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] next_idx;

  assign next_idx = (cur_idx == last_q) ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_wr_en) begin
      last_q <= (last_wr_val > MAX_IDX) ? MAX_IDX : last_wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_idx <= '0;
    else if (restart) cur_idx <= '0;
    else if (advance) cur_idx <= next_idx;
  end
endmodule

// File: rtl/scan_sample_out.sv
module scan_sample_out #(
  parameter int DATA_W = 16,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [IDX_W-1:0]  idx,
  output logic              accept
);
  assign accept = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      idx   <= '0;
    end else if (load && !valid) begin
      valid <= 1'b1;
      data  <= load_data;
      idx   <= load_idx;
    end else if (accept) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int DEPTH = 176,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              diff_mode,
  input  logic              lst_wr_en,
  input  logic [IDX_W-1:0]  lst_wr_idx,
  input  logic [CHAN_W-1:0] lst_wr_chan,
  input  logic [GAIN_W-1:0] lst_wr_gain,
  input  logic              last_wr_en,
  input  logic [IDX_W-1:0]  last_wr_val,
  input  logic              pacer_tick,
  output logic [CHAN_W-1:0] mux_chan,
  output logic [GAIN_W-1:0] mux_gain,
  output logic              mux_diff,
  output logic              conv_strobe,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DATA_W-1:0] smp_data,
  output logic [IDX_W-1:0]  smp_idx,
  output logic              scanning,
  output logic              overrun,
  output logic              chan_err
);
  scan_entry_t      rd_entry;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] conv_idx;
  logic             busy;
  logic             accept;
  logic             tick_take;
  logic             tick_drop;
  logic             bad_chan;
  logic             do_start;
  logic             host_wr_ok;

  assign host_wr_ok = !scanning;
  assign do_start   = start && !scanning && !stop;
  assign tick_take  = pacer_tick && scanning && !busy;
  assign tick_drop  = pacer_tick && scanning && busy;
  assign bad_chan   = mux_diff && (rd_entry.chan >= CHAN_W'(DIFF_PAIRS));

  scan_list_ram #(.DEPTH(DEPTH)) u_list (
    .clk      (clk),
    .wr_en    (lst_wr_en && host_wr_ok),
    .wr_idx   (lst_wr_idx),
    .wr_entry ('{chan: lst_wr_chan, gain: lst_wr_gain}),
    .rd_idx   (cur_idx),
    .rd_entry (rd_entry)
  );

  scan_index_ctl #(.DEPTH(DEPTH)) u_index (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (do_start),
    .advance     (tick_take),
    .last_wr_en  (last_wr_en && host_wr_ok),
    .last_wr_val (last_wr_val),
    .cur_idx     (cur_idx)
  );

  scan_sample_out #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (adc_done && busy),
    .load_data (adc_data),
    .load_idx  (conv_idx),
    .ready     (smp_ready),
    .valid     (smp_valid),
    .data      (smp_data),
    .idx       (smp_idx),
    .accept    (accept)
  );

  // run control and input mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      mux_diff <= 1'b0;
    end else if (stop) begin
      scanning <= 1'b0;
    end else if (do_start) begin
      scanning <= 1'b1;
      mux_diff <= diff_mode;
    end
  end

  // conversion issue and busy tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_strobe <= 1'b0;
      busy        <= 1'b0;
      mux_chan    <= '0;
      mux_gain    <= '0;
      conv_idx    <= '0;
    end else begin
      conv_strobe <= 1'b0;
      if (tick_take && !bad_chan) begin
        conv_strobe <= 1'b1;
        busy        <= 1'b1;
        mux_chan    <= rd_entry.chan;
        mux_gain    <= rd_entry.gain;
        conv_idx    <= cur_idx;
      end else if (accept) begin
        busy <= 1'b0;
      end
    end
  end

  // sticky status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun  <= 1'b0;
      chan_err <= 1'b0;
    end else if (do_start) begin
      overrun  <= 1'b0;
      chan_err <= 1'b0;
    end else begin
      if (tick_drop)             overrun  <= 1'b1;
      if (tick_take && bad_chan) chan_err <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              pacer_tick,
  input logic              scanning,
  input logic              conv_strobe,
  input logic              mux_diff,
  input logic [3:0]        mux_chan,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [DATA_W-1:0] smp_data,
  input logic [IDX_W-1:0]  smp_idx,
  input logic              overrun
);
  AST_STROBE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> $past(pacer_tick)); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe); // R3

  AST_DIFF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && mux_diff) |-> (mux_chan < 4'd8)); // R5

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !start) |=> overrun); // R6

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_idx))); // R7

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scanning) |-> !conv_strobe); // R8
endmodule

bind scan_sequencer scan_sequencer_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .pacer_tick  (pacer_tick),
  .scanning    (scanning),
  .conv_strobe (conv_strobe),
  .mux_diff    (mux_diff),
  .mux_chan    (mux_chan),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .smp_idx     (smp_idx),
  .overrun     (overrun)
);

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;
  localparam int DEPTH = 176;
  localparam int DW = 16;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, diff_mode = 0;
  logic lst_wr_en = 0;
  logic [IW-1:0] lst_wr_idx = '0;
  logic [3:0] lst_wr_chan = '0;
  logic [1:0] lst_wr_gain = '0;
  logic last_wr_en = 0;
  logic [IW-1:0] last_wr_val = '0;
  logic pacer_tick = 0;
  logic [3:0] mux_chan;
  logic [1:0] mux_gain;
  logic mux_diff, conv_strobe;
  logic adc_done = 0;
  logic [DW-1:0] adc_data = '0;
  logic smp_valid;
  logic smp_ready = 1'b1;
  logic [DW-1:0] smp_data;
  logic [IW-1:0] smp_idx;
  logic scanning, overrun, chan_err;

  always #2 clk = ~clk;

  scan_sequencer u_dut (.*);

  int checks = 0;
  int fails = 0;

  // bench model of list and index
  logic [3:0] m_chan [DEPTH];
  logic [1:0] m_gain [DEPTH];
  int m_idx = 0;
  int m_last = 0;
  logic m_diff = 0;
  logic [13:0] exp_q [$];
  int conv_seq = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: done pulse three cycles after a strobe
  initial begin
    forever begin
      @(posedge clk); #1;
      if (conv_strobe) begin
        logic [3:0] c;
        logic [1:0] g;
        c = mux_chan;
        g = mux_gain;
        repeat (3) @(posedge clk);
        #1;
        adc_done = 1'b1;
        adc_data = {4'h0, g, c, 6'(conv_seq)};
        conv_seq++;
        @(posedge clk); #1;
        adc_done = 1'b0;
      end
    end
  end

  // monitor: pops expected items at each handshake
  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected sample", int'(smp_idx), -1);
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        check(smp_idx == e[13:6], "R4/R7 sample slot index", int'(smp_idx), int'(e[13:6]));
        check(smp_data[9:6] == e[5:2], "R1 sample channel", int'(smp_data[9:6]), int'(e[5:2]));
        check(smp_data[11:10] == e[1:0], "R1 sample gain", int'(smp_data[11:10]), int'(e[1:0]));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    cyc(2);
  endtask

  task automatic write_entry(input int i, input logic [3:0] c, input logic [1:0] g);
    lst_wr_en = 1; lst_wr_idx = IW'(i); lst_wr_chan = c; lst_wr_gain = g;
    cyc(1);
    lst_wr_en = 0;
  endtask

  task automatic write_last(input int v);
    last_wr_en = 1; last_wr_val = IW'(v);
    cyc(1);
    last_wr_en = 0;
    m_last = (v > DEPTH - 1) ? DEPTH - 1 : v;
  endtask

  task automatic do_start(input logic d);
    diff_mode = d; start = 1;
    cyc(1);
    start = 0;
    m_idx = 0;
    m_diff = d;
  endtask

  task automatic do_stop();
    stop = 1;
    cyc(1);
    stop = 0;
  endtask

  // driver: issues one tick, pushes expected item, checks strobe and mux
  task automatic tick_expect();
    logic bad;
    bad = m_diff && (m_chan[m_idx] >= 4'd8);
    if (!bad) exp_q.push_back({IW'(m_idx), m_chan[m_idx], m_gain[m_idx]});
    pacer_tick = 1;
    cyc(1);
    pacer_tick = 0;
    if (bad) begin
      check(conv_strobe == 1'b0, "R5 no strobe for bad diff channel", int'(conv_strobe), 0);
      check(chan_err == 1'b1, "R5 chan_err set", int'(chan_err), 1);
    end else begin
      check(conv_strobe == 1'b1, "R3 strobe after tick", int'(conv_strobe), 1);
      check(mux_chan == m_chan[m_idx], "R3 mux channel", int'(mux_chan), int'(m_chan[m_idx]));
      check(mux_gain == m_gain[m_idx], "R3 mux gain", int'(mux_gain), int'(m_gain[m_idx]));
    end
    m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
    if (!bad) begin
      cyc(1);
      check(conv_strobe == 1'b0, "R3 strobe one cycle", int'(conv_strobe), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R9 reset state
    check(!scanning && !overrun && !chan_err, "R9 reset flags",
          int'({scanning, overrun, chan_err}), 0);
    check(!smp_valid && !conv_strobe, "R9 reset stream", int'({smp_valid, conv_strobe}), 0);

    // R1 load full list, channels out of order and repeated
    for (int i = 0; i < DEPTH; i++) begin
      m_chan[i] = 4'((i * 7) % 16);
      m_gain[i] = 2'(i % 4);
      write_entry(i, m_chan[i], m_gain[i]);
    end
    write_last(3);

    // R4 wrap after last slot 3 in single-ended mode
    do_start(1'b0);
    check(scanning == 1'b1, "R8 scanning after start", int'(scanning), 1);
    for (int k = 0; k < 6; k++) begin
      tick_expect();
      drain();
    end

    // R7 back-pressure: sample held while ready low
    smp_ready = 0;
    tick_expect();
    cyc(5);
    check(smp_valid == 1'b1, "R7 valid while stalled", int'(smp_valid), 1);
    begin
      logic [DW-1:0] held;
      held = smp_data;
      cyc(4);
      check(smp_data == held && smp_valid, "R7 data held under stall", int'(smp_data), int'(held));
    end
    // R6 tick while busy (stalled) is dropped
    pacer_tick = 1;
    cyc(1);
    pacer_tick = 0;
    check(conv_strobe == 1'b0, "R6 no strobe while busy", int'(conv_strobe), 0);
    check(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
    smp_ready = 1;
    drain();
    tick_expect();   // index not advanced by the dropped tick
    drain();
    check(overrun == 1'b1, "R6 overrun sticky", int'(overrun), 1);

    // R6 back-to-back ticks
    exp_q.push_back({IW'(m_idx), m_chan[m_idx], m_gain[m_idx]});
    pacer_tick = 1;
    cyc(1);
    check(conv_strobe == 1'b1, "R3 first of back-to-back ticks", int'(conv_strobe), 1);
    cyc(1);
    pacer_tick = 0;
    check(conv_strobe == 1'b0, "R6 second tick dropped", int'(conv_strobe), 0);
    m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
    drain();

    // R2 writes ignored while scanning
    write_entry(0, 4'd15, 2'd3);
    last_wr_en = 1; last_wr_val = 8'd10;
    cyc(1);
    last_wr_en = 0;

    // R8 stop: no strobe afterwards
    do_stop();
    check(scanning == 1'b0, "R8 scanning cleared", int'(scanning), 0);
    pacer_tick = 1;
    cyc(1);
    pacer_tick = 0;
    check(conv_strobe == 1'b0, "R8 no strobe after stop", int'(conv_strobe), 0);

    // restart: old slot 0 and old last slot still in force (R2), flags cleared (R8)
    do_start(1'b0);
    check(!overrun && !chan_err, "R8 flags cleared by start", int'({overrun, chan_err}), 0);
    for (int k = 0; k < 5; k++) begin
      tick_expect();
      drain();
    end
    check(exp_q.size() == 0, "R2 list and last unchanged", exp_q.size(), 0);

    // R5 differential mode: slot 2 holds channel 14
    do_stop();
    do_start(1'b1);
    check(mux_diff == 1'b1, "R8 diff mode latched", int'(mux_diff), 1);
    for (int k = 0; k < 5; k++) begin
      tick_expect();
      drain();
    end

    // R4 clamp of last slot to 175 and wrap over the full list
    do_stop();
    write_last(200);
    do_start(1'b0);
    for (int k = 0; k < DEPTH + 2; k++) begin
      tick_expect();
      drain();
    end
    check(exp_q.size() == 0, "R4 full list drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule